// File: doc/BRIEF.md
# Double-Buffered Overlay Window Configuration Bank

This block keeps the setup for a fixed set of overlay windows: a window enable, the first and last address of the window's pixel buffer, its top-left screen coordinate and its width and height. Software writes a front copy of every field through a simple register port. The display engine never reads the front copy. It works from a shadow copy, and each window's shadow copy is reloaded from the front copy on the vsync pulse. While loading, the shadow stage also computes the inclusive bottom-right corner of the window.

A protect bit in the shared control word holds back one window's reload. Software can then rewrite several of that window's fields across any number of frames, and the engine never sees a partly updated set. A build option swaps the per-window protect bits for one bit that holds back every window. The same control word carries one path-enable bit per window. That bit is frame-synchronous and shadowed with the rest of the window. Turning a window off therefore only takes effect at the next vsync. Reads return front values. A status word shows the enable bits the engine is using right now.

Top module: `winreg_shadow_bank`

## Requirements
- R1: After a synchronous active-low reset, every front field, the control word, the status word and every shadow output read zero.
- R2: Window w owns word addresses 8w+f, with f=0 enable (bit 0), f=1 buffer start, f=2 buffer end, f=3 top-left (x in bits 11:0, y in bits 27:16) and f=4 size (width in bits 11:0, height in bits 27:16). A write takes effect on the next clock edge. A read returns the front value combinationally and never the shadow value.
- R3: Shadow outputs change only on a clock edge where vsync is high. On that edge every field of an unprotected window takes the front values held just before the edge, all together, and the new values are visible in the following cycle.
- R4: A window whose protect bit is set keeps all of its shadow fields on vsync. The other, unprotected windows still reload.
- R5: Once a protect bit is cleared, that window's staged front values reach the shadow at the next vsync, and not before it.
- R6: Clearing a window's front enable bit leaves its shadow enable set until the next vsync on which that window is unprotected.
- R7: The shadow bottom-right coordinate on each axis is (top-left + size − 1), computed with one extra carry bit and truncated to the coordinate width. It is 0 when top-left + size is 0.
- R8: The control word sits at word address 8·NUM_WIN. Protect bits are in bits NUM_WIN−1:0 and path-enable bits in bits 16+NUM_WIN−1:16. The path-enable bits read back as written and are shadowed per window under the same vsync and protect rules.
- R9: With GLOBAL_PROTECT=1, control bit 0 holds back every window, and the other protect bits always read 0.
- R10: The status word at 8·NUM_WIN+1 returns the shadow enables in bits NUM_WIN−1:0 and the shadow path enables in bits 16+NUM_WIN−1:16. Writes to the status word or to unmapped addresses change nothing, and unmapped addresses read 0.
- R11: When a front write and vsync fall on the same edge, the shadow takes the value from before the write. The written value follows at the next vsync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | REG_AW | Word address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | REG_AW | Word address of the read |
| rd_data | output | 32 | Combinational read data |
| vsync | input | 1 | One-cycle frame boundary pulse |
| sh_en | output | NUM_WIN | Shadow window enables |
| sh_path | output | NUM_WIN | Shadow path enables |
| sh_start | output | NUM_WIN×BUF_AW | Shadow buffer start addresses |
| sh_end | output | NUM_WIN×BUF_AW | Shadow buffer end addresses |
| sh_tl_x | output | NUM_WIN×COORD_W | Shadow top-left x |
| sh_tl_y | output | NUM_WIN×COORD_W | Shadow top-left y |
| sh_br_x | output | NUM_WIN×COORD_W | Shadow inclusive bottom-right x |
| sh_br_y | output | NUM_WIN×COORD_W | Shadow inclusive bottom-right y |

## Verification
Read data is combinational, so a read is checked 1 ns after the address is set at a falling edge. A written value is due one edge after the write strobe. A shadow value is due one edge after the vsync high cycle. The bench drives every stimulus at a falling edge and samples at the next falling edge or later, so each check lands a half cycle after the edge that should produce the result. Protect and disable checks are placed between two vsync pulses. That is where an early reload would show a wrong value.

// File: rtl/wrs_pkg.sv
// Shared constants for the shadowed window register bank.
// Assumes a word-addressed map with a power-of-two stride per window.
package wrs_pkg;
    localparam int WIN_STRIDE = 8;
    localparam int FLD_W      = $clog2(WIN_STRIDE);
    localparam int FLD_CTRL   = 0;
    localparam int FLD_START  = 1;
    localparam int FLD_END    = 2;
    localparam int FLD_TL     = 3;
    localparam int FLD_SIZE   = 4;
    localparam int GLB_CTRL   = 0;
    localparam int GLB_STAT   = 1;
    localparam int HI_LSB     = 16;   // y, height and path bits start here
endpackage

// File: rtl/wrs_front_win.sv
// Front (software-visible) registers of one window.
// Assumes BUF_AW <= 32 and COORD_W <= 16; wr_sel is already qualified by wr_en.
module wrs_front_win
    import wrs_pkg::*;
#(
    parameter int BUF_AW  = 32,
    parameter int COORD_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_sel,
    input  logic [FLD_W-1:0]   wr_fld,
    input  logic [31:0]        wr_data,
    output logic               fr_en,
    output logic [BUF_AW-1:0]  fr_start,
    output logic [BUF_AW-1:0]  fr_end,
    output logic [COORD_W-1:0] fr_tlx,
    output logic [COORD_W-1:0] fr_tly,
    output logic [COORD_W-1:0] fr_w,
    output logic [COORD_W-1:0] fr_h
);
    // Capture a software write into the addressed field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fr_en    <= 1'b0;
            fr_start <= '0;
            fr_end   <= '0;
            fr_tlx   <= '0;
            fr_tly   <= '0;
            fr_w     <= '0;
            fr_h     <= '0;
        end else if (wr_sel) begin
            case (wr_fld)
                FLD_W'(FLD_CTRL):  fr_en    <= wr_data[0];
                FLD_W'(FLD_START): fr_start <= wr_data[BUF_AW-1:0];
                FLD_W'(FLD_END):   fr_end   <= wr_data[BUF_AW-1:0];
                FLD_W'(FLD_TL): begin
                    fr_tlx <= wr_data[COORD_W-1:0];
                    fr_tly <= wr_data[HI_LSB +: COORD_W];
                end
                FLD_W'(FLD_SIZE): begin
                    fr_w <= wr_data[COORD_W-1:0];
                    fr_h <= wr_data[HI_LSB +: COORD_W];
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/wrs_shadow_win.sv
// Shadow copy of one window, reloaded atomically on vsync unless held.
// Computes the inclusive bottom-right corner while loading.
// Assumes vsync is a single-cycle pulse synchronous to clk.
module wrs_shadow_win #(
    parameter int BUF_AW  = 32,
    parameter int COORD_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               vsync,
    input  logic               hold,
    input  logic               fr_en,
    input  logic               fr_path,
    input  logic [BUF_AW-1:0]  fr_start,
    input  logic [BUF_AW-1:0]  fr_end,
    input  logic [COORD_W-1:0] fr_tlx,
    input  logic [COORD_W-1:0] fr_tly,
    input  logic [COORD_W-1:0] fr_w,
    input  logic [COORD_W-1:0] fr_h,
    output logic               sh_en,
    output logic               sh_path,
    output logic [BUF_AW-1:0]  sh_start,
    output logic [BUF_AW-1:0]  sh_end,
    output logic [COORD_W-1:0] sh_tlx,
    output logic [COORD_W-1:0] sh_tly,
    output logic [COORD_W-1:0] sh_brx,
    output logic [COORD_W-1:0] sh_bry
);
    logic [COORD_W:0]   sum_x, sum_y;
    logic [COORD_W-1:0] brx_nx, bry_nx;

    // Far corner = origin + extent - 1, pinned to zero when the sum is zero.
    always_comb begin
        sum_x  = {1'b0, fr_tlx} + (COORD_W+1)'(fr_w);
        sum_y  = {1'b0, fr_tly} + (COORD_W+1)'(fr_h);
        brx_nx = (sum_x == '0) ? '0 : COORD_W'(sum_x - 1'b1);
        bry_nx = (sum_y == '0) ? '0 : COORD_W'(sum_y - 1'b1);
    end

    // Reload all fields together at an unheld vsync.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_en    <= 1'b0;
            sh_path  <= 1'b0;
            sh_start <= '0;
            sh_end   <= '0;
            sh_tlx   <= '0;
            sh_tly   <= '0;
            sh_brx   <= '0;
            sh_bry   <= '0;
        end else if (vsync && !hold) begin
            sh_en    <= fr_en;
            sh_path  <= fr_path;
            sh_start <= fr_start;
            sh_end   <= fr_end;
            sh_tlx   <= fr_tlx;
            sh_tly   <= fr_tly;
            sh_brx   <= brx_nx;
            sh_bry   <= bry_nx;
        end
    end

    // R3: nothing moves between frame boundaries.
    assert_quiet_between_vsync_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !vsync |=> ($stable(sh_en) && $stable(sh_path) && $stable(sh_start)
                    && $stable(sh_end) && $stable(sh_tlx) && $stable(sh_brx)));

    // R4: a held window keeps its whole shadow set through vsync.
    assert_hold_freezes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (vsync && hold) |=> ($stable(sh_en) && $stable(sh_start) && $stable(sh_end)
                             && $stable(sh_tly) && $stable(sh_bry)));

    // R3: an unheld vsync takes the front values seen at that edge.
    assert_reload_matches_front_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (vsync && !hold) |=> (sh_en == $past(fr_en) && sh_start == $past(fr_start)
                              && sh_tly == $past(fr_tly)));
endmodule

// File: rtl/wrs_ctrl.sv
// Shared control word: protect bits and per-window path enables.
// GLOBAL_PROTECT selects one protect bit (bit 0) for all windows.
module wrs_ctrl #(
    parameter int NUM_WIN        = 5,
    parameter bit GLOBAL_PROTECT = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_sel,
    input  logic [NUM_WIN-1:0] prot_wd,
    input  logic [NUM_WIN-1:0] path_wd,
    output logic [NUM_WIN-1:0] prot_q,
    output logic [NUM_WIN-1:0] path_q,
    output logic [NUM_WIN-1:0] hold
);
    localparam logic [NUM_WIN-1:0] KEEP = GLOBAL_PROTECT ? NUM_WIN'(1) : '1;

    // Store the control word; unused protect bits stay zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prot_q <= '0;
            path_q <= '0;
        end else if (wr_sel) begin
            prot_q <= prot_wd & KEEP;
            path_q <= path_wd;
        end
    end

    generate
        if (GLOBAL_PROTECT) begin : g_global
            // Fan the single protect bit out to every window.
            assign hold = {NUM_WIN{prot_q[0]}};

            // R9: all windows are held together or none is.
            assert_uniform_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
                (hold == '0) || (hold == '1));
        end else begin : g_per_win
            // Each window has its own hold.
            assign hold = prot_q;
        end
    endgenerate
endmodule

// File: rtl/winreg_shadow_bank.sv
// Top of the shadowed overlay window register bank.
// Word map: window w at 8w..8w+4, control at 8*NUM_WIN, status at 8*NUM_WIN+1.
// Assumes BUF_AW <= 32, COORD_W <= 16, NUM_WIN <= 16.
module winreg_shadow_bank
    import wrs_pkg::*;
#(
    parameter int NUM_WIN        = 5,
    parameter int BUF_AW         = 32,
    parameter int COORD_W        = 12,
    parameter bit GLOBAL_PROTECT = 1'b0,
    localparam int REG_AW        = $clog2(WIN_STRIDE * (NUM_WIN + 1))
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [REG_AW-1:0]               wr_addr,
    input  logic [31:0]                     wr_data,
    input  logic [REG_AW-1:0]               rd_addr,
    output logic [31:0]                     rd_data,
    input  logic                            vsync,
    output logic [NUM_WIN-1:0]              sh_en,
    output logic [NUM_WIN-1:0]              sh_path,
    output logic [NUM_WIN-1:0][BUF_AW-1:0]  sh_start,
    output logic [NUM_WIN-1:0][BUF_AW-1:0]  sh_end,
    output logic [NUM_WIN-1:0][COORD_W-1:0] sh_tl_x,
    output logic [NUM_WIN-1:0][COORD_W-1:0] sh_tl_y,
    output logic [NUM_WIN-1:0][COORD_W-1:0] sh_br_x,
    output logic [NUM_WIN-1:0][COORD_W-1:0] sh_br_y
);
    localparam int WIN_W = REG_AW - FLD_W;
    localparam logic [REG_AW-1:0] STAT_ADDR = REG_AW'(WIN_STRIDE * NUM_WIN + GLB_STAT);

    logic [WIN_W-1:0]   wr_win, rd_win;
    logic [FLD_W-1:0]   wr_fld, rd_fld;
    logic               ctl_wr;
    logic [NUM_WIN-1:0] prot_q, path_q, hold;

    logic [NUM_WIN-1:0] fr_en;
    logic [BUF_AW-1:0]  fr_start [NUM_WIN];
    logic [BUF_AW-1:0]  fr_end   [NUM_WIN];
    logic [COORD_W-1:0] fr_tlx   [NUM_WIN];
    logic [COORD_W-1:0] fr_tly   [NUM_WIN];
    logic [COORD_W-1:0] fr_w     [NUM_WIN];
    logic [COORD_W-1:0] fr_h     [NUM_WIN];

    assign wr_win = wr_addr[REG_AW-1:FLD_W];
    assign wr_fld = wr_addr[FLD_W-1:0];
    assign rd_win = rd_addr[REG_AW-1:FLD_W];
    assign rd_fld = rd_addr[FLD_W-1:0];
    assign ctl_wr = wr_en && (wr_win == WIN_W'(NUM_WIN)) && (wr_fld == FLD_W'(GLB_CTRL));

    wrs_ctrl #(.NUM_WIN(NUM_WIN), .GLOBAL_PROTECT(GLOBAL_PROTECT)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_sel  (ctl_wr),
        .prot_wd (wr_data[NUM_WIN-1:0]),
        .path_wd (wr_data[HI_LSB +: NUM_WIN]),
        .prot_q  (prot_q),
        .path_q  (path_q),
        .hold    (hold)
    );

    generate
        for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
            wrs_front_win #(.BUF_AW(BUF_AW), .COORD_W(COORD_W)) u_front (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_sel   (wr_en && (wr_win == WIN_W'(i))),
                .wr_fld   (wr_fld),
                .wr_data  (wr_data),
                .fr_en    (fr_en[i]),
                .fr_start (fr_start[i]),
                .fr_end   (fr_end[i]),
                .fr_tlx   (fr_tlx[i]),
                .fr_tly   (fr_tly[i]),
                .fr_w     (fr_w[i]),
                .fr_h     (fr_h[i])
            );

            wrs_shadow_win #(.BUF_AW(BUF_AW), .COORD_W(COORD_W)) u_shadow (
                .clk      (clk),
                .rst_n    (rst_n),
                .vsync    (vsync),
                .hold     (hold[i]),
                .fr_en    (fr_en[i]),
                .fr_path  (path_q[i]),
                .fr_start (fr_start[i]),
                .fr_end   (fr_end[i]),
                .fr_tlx   (fr_tlx[i]),
                .fr_tly   (fr_tly[i]),
                .fr_w     (fr_w[i]),
                .fr_h     (fr_h[i]),
                .sh_en    (sh_en[i]),
                .sh_path  (sh_path[i]),
                .sh_start (sh_start[i]),
                .sh_end   (sh_end[i]),
                .sh_tlx   (sh_tl_x[i]),
                .sh_tly   (sh_tl_y[i]),
                .sh_brx   (sh_br_x[i]),
                .sh_bry   (sh_br_y[i])
            );
        end
    endgenerate

    // Read mux: front fields, control word and shadow status; zero elsewhere.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (rd_win == WIN_W'(i)) begin
                case (rd_fld)
                    FLD_W'(FLD_CTRL):  rd_data[0] = fr_en[i];
                    FLD_W'(FLD_START): rd_data = 32'(fr_start[i]);
                    FLD_W'(FLD_END):   rd_data = 32'(fr_end[i]);
                    FLD_W'(FLD_TL): begin
                        rd_data[COORD_W-1:0]       = fr_tlx[i];
                        rd_data[HI_LSB +: COORD_W] = fr_tly[i];
                    end
                    FLD_W'(FLD_SIZE): begin
                        rd_data[COORD_W-1:0]       = fr_w[i];
                        rd_data[HI_LSB +: COORD_W] = fr_h[i];
                    end
                    default: ;
                endcase
            end
        end
        if (rd_win == WIN_W'(NUM_WIN)) begin
            case (rd_fld)
                FLD_W'(GLB_CTRL): begin
                    rd_data[NUM_WIN-1:0]       = prot_q;
                    rd_data[HI_LSB +: NUM_WIN] = path_q;
                end
                FLD_W'(GLB_STAT): begin
                    rd_data[NUM_WIN-1:0]       = sh_en;
                    rd_data[HI_LSB +: NUM_WIN] = sh_path;
                end
                default: ;
            endcase
        end
    end

    // R10: a write aimed at the status word leaves the control word alone.
    assert_status_readonly_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == STAT_ADDR) |=> ($stable(prot_q) && $stable(path_q)));
endmodule

// File: tb/winreg_shadow_bank_bench.sv
module winreg_shadow_bank_bench;
    localparam int NW = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, g_wr_en = 1'b0;
    logic [5:0]  wr_addr = '0, rd_addr = '0;
    logic [31:0] wr_data = '0;
    logic        vsync = 1'b0;
    logic [31:0] rd_data, g_rd_data;
    logic [NW-1:0] sh_en, sh_path, g_sh_en, g_sh_path;
    logic [NW-1:0][31:0] sh_start, sh_end, g_sh_start, g_sh_end;
    logic [NW-1:0][11:0] sh_tl_x, sh_tl_y, sh_br_x, sh_br_y;
    logic [NW-1:0][11:0] g_tl_x, g_tl_y, g_br_x, g_br_y;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;   // 50 MHz

    winreg_shadow_bank u_winreg_shadow_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .vsync(vsync),
        .sh_en(sh_en), .sh_path(sh_path), .sh_start(sh_start), .sh_end(sh_end),
        .sh_tl_x(sh_tl_x), .sh_tl_y(sh_tl_y), .sh_br_x(sh_br_x), .sh_br_y(sh_br_y)
    );

    winreg_shadow_bank #(.GLOBAL_PROTECT(1'b1)) u_winreg_shadow_bank_glob (
        .clk(clk), .rst_n(rst_n), .wr_en(g_wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(g_rd_data), .vsync(vsync),
        .sh_en(g_sh_en), .sh_path(g_sh_path), .sh_start(g_sh_start), .sh_end(g_sh_end),
        .sh_tl_x(g_tl_x), .sh_tl_y(g_tl_y), .sh_br_x(g_br_x), .sh_br_y(g_br_y)
    );

    typedef struct packed {
        logic [1:0]  op;     // 0 write, 1 read-and-compare, 2 vsync pulse
        logic [5:0]  addr;
        logic [31:0] data;   // write data or expected read data
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 32;
    localparam vec_t VEC [NV] = '{
        '{2'd1, 6'd41, 32'h0000_0000, 4'd1},   // R1 status after reset
        '{2'd1, 6'd1,  32'h0000_0000, 4'd1},   // R1 front start
        '{2'd1, 6'd40, 32'h0000_0000, 4'd1},   // R1 control word
        '{2'd0, 6'd1,  32'h1000_0000, 4'd2},
        '{2'd0, 6'd3,  32'h0020_0010, 4'd2},
        '{2'd0, 6'd4,  32'h0008_0004, 4'd2},
        '{2'd0, 6'd0,  32'h0000_0001, 4'd2},
        '{2'd0, 6'd40, 32'h001F_0000, 4'd8},
        '{2'd1, 6'd1,  32'h1000_0000, 4'd2},   // R2 readback
        '{2'd1, 6'd3,  32'h0020_0010, 4'd2},
        '{2'd1, 6'd4,  32'h0008_0004, 4'd2},
        '{2'd1, 6'd40, 32'h001F_0000, 4'd8},   // R8 path bits read back
        '{2'd1, 6'd41, 32'h0000_0000, 4'd3},   // R3 no reload without vsync
        '{2'd2, 6'd0,  32'h0,         4'd3},
        '{2'd1, 6'd41, 32'h001F_0001, 4'd3},   // R3 reload at vsync
        '{2'd0, 6'd9,  32'hAAAA_0000, 4'd4},
        '{2'd0, 6'd8,  32'h0000_0001, 4'd4},
        '{2'd0, 6'd40, 32'h001F_0001, 4'd4},   // protect window 0
        '{2'd0, 6'd0,  32'h0000_0000, 4'd6},   // disable window 0 in front
        '{2'd2, 6'd0,  32'h0,         4'd4},
        '{2'd1, 6'd41, 32'h001F_0003, 4'd4},   // R4 w0 held, w1 reloaded
        '{2'd1, 6'd0,  32'h0000_0000, 4'd2},   // R2 read is front, not shadow
        '{2'd0, 6'd40, 32'h001F_0000, 4'd5},   // unprotect
        '{2'd1, 6'd41, 32'h001F_0003, 4'd5},   // R5 not before vsync
        '{2'd2, 6'd0,  32'h0,         4'd5},
        '{2'd1, 6'd41, 32'h001F_0002, 4'd6},   // R6 disable seen now
        '{2'd0, 6'd45, 32'hFFFF_FFFF, 4'd10},
        '{2'd1, 6'd45, 32'h0000_0000, 4'd10},  // R10 unmapped reads 0
        '{2'd0, 6'd41, 32'h0000_0000, 4'd10},
        '{2'd1, 6'd41, 32'h001F_0002, 4'd10},  // R10 status write ignored
        '{2'd1, 6'd5,  32'h0000_0000, 4'd10},  // R10 unmapped window slot
        '{2'd1, 6'd9,  32'hAAAA_0000, 4'd2}    // R2 other window readback
    };

    task automatic check(input int req, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input bit glob, input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_addr = a; wr_data = d;
        if (glob) g_wr_en = 1'b1; else wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; g_wr_en = 1'b0;
    endtask

    task automatic pulse_vsync();
        @(negedge clk);
        vsync = 1'b1;
        @(negedge clk);
        vsync = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d, output logic [31:0] gd);
        @(negedge clk);
        rd_addr = a;
        #1;
        d = rd_data;
        gd = g_rd_data;
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired: actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] d, gd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: shadow outputs at reset
        #1;
        check(1, "shadow enables", 32'(sh_en), 32'h0);
        check(1, "shadow start w0", sh_start[0], 32'h0);
        check(1, "shadow br x w0", 32'(sh_br_x[0]), 32'h0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            case (VEC[i].op)
                2'd0: wr(1'b0, VEC[i].addr, VEC[i].data);
                2'd1: begin
                    rd(VEC[i].addr, d, gd);
                    check(int'(VEC[i].req), $sformatf("vector %0d read", i), d, VEC[i].data);
                end
                default: pulse_vsync();
            endcase
        end

        // R3: every field of window 0 came across together
        @(negedge clk);
        check(3, "sh_start w0", sh_start[0], 32'h1000_0000);
        check(3, "sh_tl_x w0", 32'(sh_tl_x[0]), 32'd16);
        check(3, "sh_tl_y w0", 32'(sh_tl_y[0]), 32'd32);
        check(3, "sh_start w1", sh_start[1], 32'hAAAA_0000);
        // R7 for window 0: 16+4-1, 32+8-1
        check(7, "sh_br_x w0", 32'(sh_br_x[0]), 32'd19);
        check(7, "sh_br_y w0", 32'(sh_br_y[0]), 32'd39);
        // R8: shadowed path enables
        check(8, "sh_path", 32'(sh_path), 32'h1F);

        // R7: ordinary, wrap-to-nonzero and zero-sum corners
        wr(1'b0, 6'd19, 32'h0032_0064);   // w2 tl x=100 y=50
        wr(1'b0, 6'd20, 32'h000A_0014);   // w2 size 20x10
        wr(1'b0, 6'd27, 32'h0000_0FFF);   // w3 tl x=4095 y=0
        wr(1'b0, 6'd28, 32'h0000_0001);   // w3 size 1x0
        pulse_vsync();
        check(7, "sh_br_x w2", 32'(sh_br_x[2]), 32'd119);
        check(7, "sh_br_y w2", 32'(sh_br_y[2]), 32'd59);
        check(7, "sh_br_x w3 carry", 32'(sh_br_x[3]), 32'hFFF);
        check(7, "sh_br_y w3 zero", 32'(sh_br_y[3]), 32'h0);

        // R11: write colliding with vsync
        wr(1'b0, 6'd33, 32'h0000_0055);
        pulse_vsync();
        @(negedge clk);
        wr_addr = 6'd33; wr_data = 32'h0000_0066; wr_en = 1'b1; vsync = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; vsync = 1'b0;
        check(11, "sh_start w4 after collision", sh_start[4], 32'h0000_0055);
        pulse_vsync();
        check(11, "sh_start w4 next frame", sh_start[4], 32'h0000_0066);

        // R9: single protect bit in the global-protect build
        wr(1'b1, 6'd40, 32'h001F_001F);
        rd(6'd40, d, gd);
        check(9, "global ctrl readback", gd, 32'h001F_0001);
        wr(1'b1, 6'd25, 32'h0000_0077);
        wr(1'b1, 6'd16, 32'h0000_0001);
        pulse_vsync();
        check(9, "global held w3 start", g_sh_start[3], 32'h0);
        check(9, "global held enables", 32'(g_sh_en), 32'h0);
        wr(1'b1, 6'd40, 32'h001F_0000);
        pulse_vsync();
        check(9, "global released w3 start", g_sh_start[3], 32'h0000_0077);
        check(9, "global released enables", 32'(g_sh_en), 32'h04);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule